// File: doc/BRIEF.md
# Serial Stream Slice with Shadow Swap

This block is one lane of a programmable serial streaming engine. A 32-bit working register shifts one bit per shift event toward its least significant end, and its LSB drives the outgoing pin. The bit that enters at the top is either the bit just shifted out, so a pattern repeats forever, or a sample of the incoming pin, so the register captures a serial word. Shift events come from a prescaler that divides the core clock by a programmable amount and starts from a programmable phase. Two slices given the same divider and phase shift on the same cycles.

A position counter counts shift events. On the event where it is already at zero, the working register and a 32-bit shadow register trade contents and the counter reloads. Control logic writes the next outgoing pattern into the shadow register while the current one streams out. After the trade it reads the captured word back from the shadow register. A stop control lets the slice finish its current word, complete the trade and reload, and then freeze at the word boundary. A one-cycle pulse marks each trade, and a status flag shows when the slice is frozen.

Top module: `stream_slice`

## Requirements
- R1: While reset is asserted and right after it, `pin_out`, `shadow_rdata`, `swap_pulse` and `stopped` are all zero. The prescaler preset and phase reset to 0, and the position count and reload both reset to 31.
- R2: With preset P, while running and not frozen, a shift event occurs every P+1 clock cycles.
- R3: A configuration write loads the phase value C into the prescaler. With run enabled from the next cycle, the first shift event takes effect on the (C+1)-th clock edge after the write.
- R4: `pin_out` is bit 0 of the working register. Each shift event moves the register one place toward bit 0.
- R5: With `src_ext`=0 the bit leaving bit 0 re-enters at bit 31. With a reload of 31, after 32 shift events the shadow register holds the original pattern.
- R6: With `src_ext`=1 the value of `pin_in` at each shift event enters at bit 31. After 32 events the first sampled bit sits in bit 0.
- R7: The position counter decrements on every shift event. On a shift event that finds it at zero it reloads, so a reload value N gives a swap every N+1 shift events.
- R8: On a swap event the working register takes the old shadow contents. The shadow register takes the working register value with that event's shift applied, and it is visible on `shadow_rdata`.
- R9: `swap_pulse` is high for exactly the one cycle after each swap edge.
- R10: If `stop_after_swap` is high at a swap, `stopped` rises and no further shift occurs while the control stays high. When the control is lowered, `stopped` clears on the next edge, and shifting resumes from the already-reloaded position.
- R11: While `run_en` is low, the prescaler phase, the position and both registers hold.
- R12: A direct write (`act_wr`, `shd_wr`) is visible on the next cycle and overrides any shift or swap update of that register on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Lets the prescaler advance |
| stop_after_swap | input | 1 | Freeze the slice at the next swap |
| src_ext | input | 1 | 1: fill from `pin_in`; 0: recirculate |
| pin_in | input | 1 | Incoming serial bit |
| cfg_wr | input | 1 | Load the four configuration fields |
| cfg_preset | input | 12 | Prescaler reload value P |
| cfg_phase | input | 12 | Prescaler start value C |
| cfg_pos_count | input | 8 | Position counter start value |
| cfg_pos_reload | input | 8 | Position counter reload value |
| act_wr | input | 1 | Write the working register |
| act_wdata | input | 32 | Working register write data |
| shd_wr | input | 1 | Write the shadow register |
| shd_wdata | input | 32 | Shadow register write data |
| pin_out | output | 1 | Outgoing serial bit |
| shadow_rdata | output | 32 | Shadow register contents |
| swap_pulse | output | 1 | One-cycle swap marker |
| stopped | output | 1 | Slice frozen after a swap |

## Verification
A prescaler phase that is off by one shows up as a `pin_out` transition one cycle early or late, within P+1 cycles of the fault. A position counter that slips moves `swap_pulse` and corrupts the word seen on `shadow_rdata` at the very next swap. A bad feedback or capture bit stays hidden until that swap exposes the stored word. The bench therefore compares all four outputs on every cycle against a model derived from the requirements, so these faults appear no later than one word period after they arise.

// File: rtl/stream_slice_pkg.sv
package stream_slice_pkg;

    typedef enum logic {
        SRC_LOOP = 1'b0,
        SRC_PIN  = 1'b1
    } src_sel_e;

endpackage

// File: rtl/slice_prescaler.sv
module slice_prescaler #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_preset,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             advance,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] preset;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = advance && (st_q.cnt == '0);
        if (cfg_wr) begin
            st_d.cnt    = cfg_phase;
            st_d.preset = cfg_preset;
        end else if (advance) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.preset;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RELOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !cfg_wr |=> st_q.cnt == st_q.preset); // R2
    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> st_q.cnt == $past(cfg_phase)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance && !cfg_wr |=> $stable(st_q.cnt)); // R11

endmodule

// File: rtl/slice_position.sv
module slice_position #(
    parameter int POS_W    = 8,
    parameter int POS_INIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [POS_W-1:0] cfg_count,
    input  logic [POS_W-1:0] cfg_reload,
    input  logic             tick,
    output logic             wrap
);

    localparam logic [POS_W-1:0] INIT_V = POS_W'(POS_INIT);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] rld;
    } pos_state_t;

    pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.pos == '0);
        if (cfg_wr) begin
            st_d.pos = cfg_count;
            st_d.rld = cfg_reload;
        end else if (wrap) begin
            st_d.pos = st_q.rld;
        end else if (tick) begin
            st_d.pos = st_q.pos - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos <= INIT_V;
            st_q.rld <= INIT_V;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !cfg_wr |=> st_q.pos == st_q.rld); // R7
    AST_DEC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wrap && !cfg_wr |=> st_q.pos == $past(st_q.pos) - 1'b1); // R7
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cfg_wr |=> $stable(st_q.pos)); // R11

endmodule

// File: rtl/slice_shifter.sv
module slice_shifter
    import stream_slice_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wrap,
    input  src_sel_e          src_sel,
    input  logic              pin_in,
    input  logic              act_wr,
    input  logic [DATA_W-1:0] act_wdata,
    input  logic              shd_wr,
    input  logic [DATA_W-1:0] shd_wdata,
    output logic              pin_out,
    output logic [DATA_W-1:0] shadow_data
);

    typedef struct packed {
        logic [DATA_W-1:0] act;
        logic [DATA_W-1:0] shd;
    } sh_state_t;

    sh_state_t         st_d, st_q;
    logic              feed;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        feed    = (src_sel == SRC_PIN) ? pin_in : st_q.act[0];
        shifted = {feed, st_q.act[DATA_W-1:1]};
        if (tick) begin
            if (wrap) begin
                st_d.act = st_q.shd;
                st_d.shd = shifted;
            end else begin
                st_d.act = shifted;
            end
        end
        if (act_wr) st_d.act = act_wdata;
        if (shd_wr) st_d.shd = shd_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out     = st_q.act[0];
    assign shadow_data = st_q.shd;

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wrap && !act_wr |=> st_q.act[DATA_W-2:0] == $past(st_q.act[DATA_W-1:1])); // R4
    AST_SWAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !act_wr |=> st_q.act == $past(st_q.shd)); // R8
    AST_SWAP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !shd_wr |=> st_q.shd[DATA_W-2:0] == $past(st_q.act[DATA_W-1:1])); // R8
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !act_wr |=> $stable(st_q.act)); // R11

endmodule

// File: rtl/stream_slice.sv
module stream_slice
    import stream_slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int POS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              stop_after_swap,
    input  logic              src_ext,
    input  logic              pin_in,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_preset,
    input  logic [CNT_W-1:0]  cfg_phase,
    input  logic [POS_W-1:0]  cfg_pos_count,
    input  logic [POS_W-1:0]  cfg_pos_reload,
    input  logic              act_wr,
    input  logic [DATA_W-1:0] act_wdata,
    input  logic              shd_wr,
    input  logic [DATA_W-1:0] shd_wdata,
    output logic              pin_out,
    output logic [DATA_W-1:0] shadow_rdata,
    output logic              swap_pulse,
    output logic              stopped
);

    localparam int POS_INIT = DATA_W - 1;

    typedef struct packed {
        logic stop;
        logic swap;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       advance;
    logic       tick;
    logic       wrap;

    assign advance = run_en && !st_q.stop;

    slice_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_preset (cfg_preset),
        .cfg_phase  (cfg_phase),
        .advance    (advance),
        .tick       (tick)
    );

    slice_position #(.POS_W(POS_W), .POS_INIT(POS_INIT)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_count  (cfg_pos_count),
        .cfg_reload (cfg_pos_reload),
        .tick       (tick),
        .wrap       (wrap)
    );

    slice_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .wrap        (wrap),
        .src_sel     (src_sel_e'(src_ext)),
        .pin_in      (pin_in),
        .act_wr      (act_wr),
        .act_wdata   (act_wdata),
        .shd_wr      (shd_wr),
        .shd_wdata   (shd_wdata),
        .pin_out     (pin_out),
        .shadow_data (shadow_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.swap = wrap;
        if (st_q.stop) st_d.stop = stop_after_swap;
        else           st_d.stop = wrap && stop_after_swap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign swap_pulse = st_q.swap;
    assign stopped    = st_q.stop;

    AST_NO_SHIFT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stop |-> !tick); // R10
    AST_STOP_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && stop_after_swap |=> st_q.stop); // R10
    AST_PULSE_AFTER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> swap_pulse); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse && !wrap |=> !swap_pulse); // R9

endmodule

// File: tb/stream_slice_bench.sv
module stream_slice_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, stop_ctl, src_ext, pin_in, cfg_wr, act_wr, shd_wr;
    logic [11:0] cfg_preset, cfg_phase;
    logic [7:0]  cfg_pos_count, cfg_pos_reload;
    logic [31:0] act_wdata, shd_wdata;
    logic        pin_out, swap_pulse, stopped;
    logic [31:0] shadow_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    stream_slice u_stream_slice (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .stop_after_swap(stop_ctl),
        .src_ext(src_ext), .pin_in(pin_in), .cfg_wr(cfg_wr),
        .cfg_preset(cfg_preset), .cfg_phase(cfg_phase),
        .cfg_pos_count(cfg_pos_count), .cfg_pos_reload(cfg_pos_reload),
        .act_wr(act_wr), .act_wdata(act_wdata), .shd_wr(shd_wr), .shd_wdata(shd_wdata),
        .pin_out(pin_out), .shadow_rdata(shadow_rdata),
        .swap_pulse(swap_pulse), .stopped(stopped)
    );

    // Requirement-level model, advanced on every rising edge
    logic [11:0] m_cnt, m_pre;
    logic [7:0]  m_pos, m_rld;
    logic [31:0] m_act, m_shd;
    logic        m_stop, m_swp;

    always @(posedge clk) begin : model
        logic adv, tk, wr;
        logic [31:0] shf, na, ns;
        if (!rst_n) begin
            m_cnt = '0; m_pre = '0; m_pos = 8'd31; m_rld = 8'd31;
            m_act = '0; m_shd = '0; m_stop = 1'b0; m_swp = 1'b0;
        end else begin
            adv = run_en && !m_stop;
            tk  = adv && (m_cnt == 12'd0);
            wr  = tk && (m_pos == 8'd0);
            shf = {(src_ext ? pin_in : m_act[0]), m_act[31:1]};
            na = m_act; ns = m_shd;
            if (wr) begin na = m_shd; ns = shf; end
            else if (tk) na = shf;
            if (act_wr) na = act_wdata;
            if (shd_wr) ns = shd_wdata;
            m_act = na; m_shd = ns;
            if (cfg_wr) begin m_cnt = cfg_phase; m_pre = cfg_preset; end
            else if (adv) m_cnt = (m_cnt == 12'd0) ? m_pre : m_cnt - 12'd1;
            if (cfg_wr) begin m_pos = cfg_pos_count; m_rld = cfg_pos_reload; end
            else if (wr) m_pos = m_rld;
            else if (tk) m_pos = m_pos - 8'd1;
            m_stop = m_stop ? stop_ctl : (wr && stop_ctl);
            m_swp  = wr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk("R4 pin_out", {31'd0, pin_out}, {31'd0, m_act[0]});
        chk("R8 shadow", shadow_rdata, m_shd);
        chk("R9 swap_pulse", {31'd0, swap_pulse}, {31'd0, m_swp});
        chk("R10 stopped", {31'd0, stopped}, {31'd0, m_stop});
    endtask

    task automatic do_cfg(input int p, input int c, input int pc, input int pr);
        cfg_wr = 1'b1; cfg_preset = 12'(p); cfg_phase = 12'(c);
        cfg_pos_count = 8'(pc); cfg_pos_reload = 8'(pr);
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wr_act(input logic [31:0] d);
        act_wr = 1'b1; act_wdata = d; step(); act_wr = 1'b0;
    endtask

    task automatic wr_shd(input logic [31:0] d);
        shd_wr = 1'b1; shd_wdata = d; step(); shd_wr = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!swap_pulse && n < 200);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat, got, snap;
        int n;
        void'($urandom(32'd1357));
        rst_n = 1'b0; run_en = 0; stop_ctl = 0; src_ext = 0; pin_in = 0;
        cfg_wr = 0; act_wr = 0; shd_wr = 0; cfg_preset = 0; cfg_phase = 0;
        cfg_pos_count = 0; cfg_pos_reload = 0; act_wdata = 0; shd_wdata = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1 pin_out", {31'd0, pin_out}, 32'd0);
        chk("R1 shadow", shadow_rdata, 32'd0);
        chk("R1 swap_pulse", {31'd0, swap_pulse}, 32'd0);
        chk("R1 stopped", {31'd0, stopped}, 32'd0);

        // R12: direct writes visible next cycle
        wr_act(32'h8000_0001);
        chk("R12 act write", {31'd0, pin_out}, 32'd1);
        wr_shd(32'h1234_5678);
        chk("R12 shd write", shadow_rdata, 32'h1234_5678);

        // R4/R5: self-loop, one bit per cycle, 32-shift word
        pat = 32'hC3A5_0F96;
        do_cfg(0, 0, 31, 31);
        wr_act(pat);
        wr_shd(32'd0);
        src_ext = 0; run_en = 1;
        for (int k = 0; k < 32; k++) begin
            got[k] = pin_out;
            step();
        end
        run_en = 0;
        chk("R4 serial order", got, pat);
        chk("R5 recirculated word", shadow_rdata, pat);
        chk("R9 pulse at word end", {31'd0, swap_pulse}, 32'd1);
        chk("R8 active from shadow", {31'd0, pin_out}, 32'd0);

        // R6: external capture
        pat = 32'h5A3C_F00D;
        wr_act(32'd0);
        wr_shd(32'd0);
        src_ext = 1; run_en = 1;
        for (int k = 0; k < 32; k++) begin
            pin_in = pat[k];
            step();
        end
        run_en = 0; src_ext = 0; pin_in = 0;
        chk("R6 captured word", shadow_rdata, pat);

        // R2: divide by P+1
        do_cfg(4, 0, 0, 0);
        run_en = 1;
        wait_pulse(n);
        wait_pulse(n);
        chk("R2 interval preset 4", 32'(n), 32'd5);
        run_en = 0; step(); step();

        // R3: phase start
        do_cfg(9, 6, 0, 0);
        run_en = 1;
        wait_pulse(n);
        chk("R3 first event phase 6", 32'(n), 32'd7);
        run_en = 0; step();

        // R7: reload 7 gives 8 shifts per swap
        do_cfg(0, 0, 7, 7);
        run_en = 1;
        wait_pulse(n);
        chk("R7 first swap", 32'(n), 32'd8);
        wait_pulse(n);
        chk("R7 swap period", 32'(n), 32'd8);
        run_en = 0; step();

        // R11: idle cycles hold phase
        do_cfg(2, 0, 0, 0);
        run_en = 1;
        wait_pulse(n);
        run_en = 0;
        snap = shadow_rdata;
        repeat (4) step();
        chk("R11 shadow held", shadow_rdata, snap);
        run_en = 1;
        wait_pulse(n);
        chk("R11 resumed interval", 32'(n), 32'd3);
        run_en = 0; step();

        // R10: stop after swap
        do_cfg(0, 0, 3, 3);
        wr_act(32'hF0F0_1234);
        pat = 32'h0000_0006;
        wr_shd(pat);
        stop_ctl = 1; run_en = 1;
        repeat (4) step();
        chk("R10 stopped set", {31'd0, stopped}, 32'd1);
        chk("R10 new word out", {31'd0, pin_out}, {31'd0, pat[0]});
        snap = shadow_rdata;
        repeat (20) step();
        chk("R10 frozen pin", {31'd0, pin_out}, {31'd0, pat[0]});
        chk("R10 frozen shadow", shadow_rdata, snap);
        stop_ctl = 0;
        step();
        chk("R10 stopped cleared", {31'd0, stopped}, 32'd0);
        chk("R10 no shift on clear", {31'd0, pin_out}, {31'd0, pat[0]});
        step();
        chk("R10 resumed shift", {31'd0, pin_out}, {31'd0, pat[1]});
        repeat (2) step();
        chk("R10 no early swap", {31'd0, swap_pulse}, 32'd0);
        step();
        chk("R10 reloaded position", {31'd0, swap_pulse}, 32'd1);
        run_en = 0; step();

        // Random mix against the model (R4, R8, R9, R10, R12 per cycle)
        for (int i = 0; i < 4000; i++) begin
            cfg_wr = ($urandom_range(0, 199) == 0);
            if (cfg_wr) begin
                cfg_preset = 12'($urandom_range(0, 3));
                cfg_phase = 12'($urandom_range(0, 3));
                cfg_pos_count = 8'($urandom_range(0, 31));
                cfg_pos_reload = ($urandom_range(0, 1) == 0) ? 8'd31 : 8'($urandom_range(0, 7));
            end
            run_en = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 99) == 0) stop_ctl = ~stop_ctl;
            if ($urandom_range(0, 49) == 0) src_ext = ~src_ext;
            pin_in = 1'($urandom_range(0, 1));
            act_wr = ($urandom_range(0, 49) == 0);
            act_wdata = $urandom();
            shd_wr = ($urandom_range(0, 49) == 0);
            shd_wdata = $urandom();
            step();
        end
        cfg_wr = 0; act_wr = 0; shd_wr = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule